// File: doc/BRIEF.md
# Synchronous Serial Shift Port

The block is a byte-wide synchronous serial port for a small controller. It sends one byte on a data-out pin while it takes in one byte from a data-in pin. One register holds both bytes. Bits leave at the MSB end or at the LSB end, as a configuration input selects. Received bits enter at the opposite end, so that after eight bits the register holds the incoming byte in the same order.

The shift clock has two sources, chosen by software:
- **Internal:** the port drives the clock pin itself. It toggles the pin once for each prescaler enable pulse while a transfer runs.
- **External:** a master drives the clock pin. The block passes that pin through a two-flop synchroniser and then detects its edges.

The clock idles high. Data out changes on a falling edge and data in is sampled on a rising edge. When the serial function is disabled, the clock pin becomes a free-running clock output carrying the prescaler clock-out signal.

The processor side has four signals:
- a byte write, accepted only while the port is idle;
- a start pulse;
- a parallel read of the shift register;
- a done flag, which rises after the eighth sampling edge and drops on the next accepted start.

Top module: `sio_shift_unit`

## Requirements
- R1: After reset, done is 0, sdo is 1, rd_data is 0, and the internal shift clock is high.
- R2: A write while idle loads wr_data into the shift register, which rd_data shows in the next cycle. A write during a transfer is ignored.
- R3: A start is accepted only when the serial function is enabled and no transfer is running. An accepted start clears done in the next cycle.
- R4: With the internal clock selected, sck_out toggles on each presc_tick during a transfer, starts and ends high, and sck_oe is 1.
- R5: With cfg_lsb_first=0, each falling shift-clock edge sets sdo to the next bit, starting at bit 7 of the written byte.
- R6: With cfg_lsb_first=1, each falling shift-clock edge sets sdo to the next bit, starting at bit 0.
- R7: Each rising shift-clock edge samples sdi. After eight samples rd_data holds the received byte: first bit in bit 7 when cfg_lsb_first=0, in bit 0 when it is 1.
- R8: done rises on the eighth rising edge, and the transfer then stops. done and an active transfer are never true together.
- R9: With the external clock selected, sck_oe is 0. A change on sck_in acts on the shift register on the third clock edge after it.
- R10: With cfg_enable=0, sck_out equals presc_clkout, sck_oe is 1, and start has no effect on the register or on done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Serial function enable (0: clock pin carries prescaler clock-out) |
| cfg_lsb_first | input | 1 | Bit order: 1 sends and receives LSB first |
| cfg_ext_clk | input | 1 | Shift clock source: 1 external pin, 0 internal |
| presc_tick | input | 1 | Prescaler enable pulse; each one is a half period of the internal shift clock |
| presc_clkout | input | 1 | Prescaler clock-out level, driven to the pin when the port is disabled |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to send |
| start | input | 1 | Start-transfer pulse |
| rd_data | output | 8 | Shift register contents (received byte after done) |
| done | output | 1 | Transfer complete flag |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sck_in | input | 1 | Clock pin input (external shift clock) |
| sck_out | output | 1 | Clock pin output value |
| sck_oe | output | 1 | Clock pin output enable |

## Verification
Each kind of internal fault shows at the ports soon after it occurs:
- A corrupted shift register shows on sdo at the next falling shift-clock edge, and in rd_data once the transfer ends.
- A bit counter off by one moves the rise of done by one full shift-clock period.
- A wrong internal clock phase appears on sck_out in the same cycle.
- A missing or extra synchroniser stage moves the sdo update by one cycle after an sck_in change.

The reference model is compared on every clock, so each of these faults is reported within the cycle in which the port value first differs.

// File: rtl/sio_pkg.sv
package sio_pkg;

  // One clock-domain-local edge report of a shift clock
  typedef struct packed {
    logic rise;
    logic fall;
  } sclk_edge_t;

  // Edge report from an old and a new level
  function automatic sclk_edge_t edge_of(input logic prev_lvl, input logic new_lvl);
    sclk_edge_t e;
    e.rise = new_lvl & ~prev_lvl;
    e.fall = ~new_lvl & prev_lvl;
    return e;
  endfunction

endpackage

// File: rtl/sio_edge_sync.sv
module sio_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pin,
  output sio_pkg::sclk_edge_t     ev
);
  // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-1:0], pin};
  end

  assign ev = sio_pkg::edge_of(chain[STAGES], chain[STAGES-1]);
endmodule

// File: rtl/sio_clkgen.sv
module sio_clkgen (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                busy,
  input  logic                tick,
  output logic                sck,
  output sio_pkg::sclk_edge_t ev
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sck <= 1'b1;
    else if (!busy) sck <= 1'b1;
    else if (tick)  sck <= ~sck;
  end

  // The edge the register is about to take at this clock
  assign ev.fall = busy & tick & sck;
  assign ev.rise = busy & tick & ~sck;
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lsb_first,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              start_ok,
  input  logic              ev_rise,
  input  logic              ev_fall,
  input  logic              sdi,
  output logic [DATA_W-1:0] sr,
  output logic              sdo,
  output logic              busy,
  output logic              done
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0] cnt;

  function automatic logic head_bit(input logic [DATA_W-1:0] v, input logic lsb);
    return lsb ? v[0] : v[DATA_W-1];
  endfunction

  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] v,
                                                 input logic b, input logic lsb);
    return lsb ? {b, v[DATA_W-1:1]} : {v[DATA_W-2:0], b};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      sdo  <= 1'b1;
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (wr_en) sr <= wr_data;
      if (start_ok) begin
        busy <= 1'b1;
        done <= 1'b0;
        cnt  <= '0;
      end
    end else begin
      if (ev_fall) sdo <= head_bit(sr, lsb_first);
      if (ev_rise) begin
        sr  <= shift_in(sr, sdi, lsb_first);
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sio_shift_unit.sv
module sio_shift_unit #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_lsb_first,
  input  logic              cfg_ext_clk,
  input  logic              presc_tick,
  input  logic              presc_clkout,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              start,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  input  logic              sdi,
  output logic              sdo,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sck_oe
);
  sio_pkg::sclk_edge_t ext_ev, int_ev;
  logic busy, int_sck, start_ok;
  logic ext_rise, ext_fall, sel_rise, sel_fall;
  logic [DATA_W-1:0] sr;

  sio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(sck_in), .ev(ext_ev)
  );

  sio_clkgen u_gen (
    .clk(clk), .rst_n(rst_n), .busy(busy), .tick(presc_tick),
    .sck(int_sck), .ev(int_ev)
  );

  assign ext_rise = ext_ev.rise;
  assign ext_fall = ext_ev.fall;
  assign sel_rise = cfg_ext_clk ? ext_ev.rise : int_ev.rise;
  assign sel_fall = cfg_ext_clk ? ext_ev.fall : int_ev.fall;
  assign start_ok = start & cfg_enable & ~busy;

  sio_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .lsb_first(cfg_lsb_first),
    .wr_en(wr_en), .wr_data(wr_data), .start_ok(start_ok),
    .ev_rise(sel_rise), .ev_fall(sel_fall), .sdi(sdi),
    .sr(sr), .sdo(sdo), .busy(busy), .done(done)
  );

  assign rd_data = sr;

  // Clock pin sharing
  always_comb begin
    if (!cfg_enable) begin
      sck_out = presc_clkout;
      sck_oe  = 1'b1;
    end else if (cfg_ext_clk) begin
      sck_out = 1'b1;
      sck_oe  = 1'b0;
    end else begin
      sck_out = int_sck;
      sck_oe  = 1'b1;
    end
  end
endmodule

// File: rtl/sio_shift_unit_checker.sv
module sio_shift_unit_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_enable,
  input logic              cfg_ext_clk,
  input logic              wr_en,
  input logic              busy,
  input logic              done,
  input logic              sdo,
  input logic [DATA_W-1:0] sr,
  input logic              start_ok,
  input logic              sel_rise,
  input logic              sel_fall,
  input logic              ext_rise,
  input logic              ext_fall,
  input logic              int_sck
);
  assert_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && !sel_rise) |=> $stable(sr));

  assert_start_clears_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (!done && busy));

  assert_sck_high_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && !cfg_ext_clk) |-> int_sck);

  assert_sdo_moves_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $past(sel_fall && busy));

  assert_done_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(sel_rise && busy));

  assert_busy_excludes_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_ext_waits_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_ext_clk && !ext_rise && !ext_fall) |=> $stable(sdo));

  assert_disabled_no_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_enable && !busy) |=> !busy);
endmodule

bind sio_shift_unit sio_shift_unit_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_ext_clk(cfg_ext_clk),
  .wr_en(wr_en), .busy(busy), .done(done), .sdo(sdo), .sr(sr),
  .start_ok(start_ok), .sel_rise(sel_rise), .sel_fall(sel_fall),
  .ext_rise(ext_rise), .ext_fall(ext_fall), .int_sck(int_sck)
);

// File: tb/sio_shift_unit_test.sv
`timescale 1ns/1ps
module sio_shift_unit_test;
  logic clk = 1'b0;
  logic rst_n, cfg_enable, cfg_lsb_first, cfg_ext_clk;
  logic presc_tick = 1'b0, presc_clkout = 1'b0;
  logic wr_en, start, sdi = 1'b0, sck_in;
  logic [7:0] wr_data, rd_data;
  logic done, sdo, sck_out, sck_oe;

  always #2.5 clk = ~clk;

  sio_shift_unit uut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_lsb_first(cfg_lsb_first),
    .cfg_ext_clk(cfg_ext_clk), .presc_tick(presc_tick), .presc_clkout(presc_clkout),
    .wr_en(wr_en), .wr_data(wr_data), .start(start), .rd_data(rd_data), .done(done),
    .sdi(sdi), .sdo(sdo), .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe)
  );

  int total = 0, bad = 0, cyc = 0;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit       m_busy, m_done, m_sck, m_sdo;
  bit [7:0] m_tx, m_rx, m_rd;
  int       m_bits, m_outs;
  bit       pin_q[$];           // past sck_in samples, newest at the back
  bit [7:0] pat_r = 8'h00;      // pattern fed on sdi
  bit [7:0] tx_seen;
  int       fidx;
  bit       prev_sck_out = 1'b1;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_sck = 1; m_sdo = 1;
      m_tx = 0; m_rx = 0; m_rd = 0; m_bits = 0; m_outs = 0;
      pin_q = '{1'b1, 1'b1, 1'b1};
    end else begin
      bit old_busy, r, f, lvl_new, lvl_old;
      old_busy = m_busy;
      lvl_old = pin_q[0];
      lvl_new = pin_q[1];
      if (cfg_ext_clk) begin
        r = old_busy && lvl_new && !lvl_old;
        f = old_busy && !lvl_new && lvl_old;
      end else begin
        r = old_busy && presc_tick && !m_sck;
        f = old_busy && presc_tick && m_sck;
      end
      if (!old_busy) begin
        if (wr_en) begin m_tx = wr_data; m_rd = wr_data; end
        if (start && cfg_enable) begin
          m_busy = 1; m_done = 0; m_bits = 0; m_outs = 0; m_rx = 0;
        end
      end else begin
        if (f && m_outs < 8) begin
          m_sdo = cfg_lsb_first ? m_tx[m_outs] : m_tx[7 - m_outs];
          m_outs++;
        end
        if (r) begin
          if (cfg_lsb_first) m_rx[m_bits] = sdi; else m_rx[7 - m_bits] = sdi;
          m_bits++;
          if (m_bits == 8) begin m_busy = 0; m_done = 1; m_rd = m_rx; end
        end
      end
      if (!old_busy) m_sck = 1;
      else if (presc_tick) m_sck = !m_sck;
      void'(pin_q.pop_front());
      pin_q.push_back(sck_in);
    end
    #1;
    if (rst_n) begin
      check("R8 done", done, m_done);
      check("R5 R6 sdo", sdo, m_sdo);
      check("R4 R10 sck_out", sck_out,
            !cfg_enable ? presc_clkout : (cfg_ext_clk ? 1 : m_sck));
      check("R9 sck_oe", sck_oe, !(cfg_enable && cfg_ext_clk));
      if (!m_busy) check("R7 R2 rd_data", rd_data, m_rd);
      if (cfg_enable && !cfg_ext_clk && prev_sck_out && !sck_out && fidx < 8) begin
        if (cfg_lsb_first) tx_seen[fidx] = sdo; else tx_seen[7 - fidx] = sdo;
        fidx++;
      end
    end
    prev_sck_out = sck_out;
  end

  // ---------------- free-running stimulus ----------------
  int clkout_div = 0;
  always @(negedge clk) begin
    presc_tick <= ~presc_tick;
    clkout_div <= (clkout_div == 2) ? 0 : clkout_div + 1;
    if (clkout_div == 2) presc_clkout <= ~presc_clkout;
    sdi <= cfg_lsb_first ? pat_r[m_bits & 7] : pat_r[7 - (m_bits & 7)];
  end

  task automatic summary_and_end();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc == 100000) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      summary_and_end();
    end
  end

  task automatic wait_done();
    int n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    if (!done) begin
      total++; bad++;
      $display("FAIL R8 watchdog waiting for done actual=0 expected=1");
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic xfer(input bit [7:0] tx, input bit [7:0] pat, input bit lsb,
                      input bit ext, input bit poke);
    @(negedge clk);
    cfg_lsb_first = lsb; cfg_ext_clk = ext; pat_r = pat;
    wr_en = 1; wr_data = tx;
    @(negedge clk);
    wr_en = 0;
    check("R2 write loads", rd_data, tx);
    tx_seen = 0; fidx = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    check("R3 start clears done", done, 0);
    if (ext) begin
      for (int k = 0; k < 8; k++) begin
        repeat (4) @(negedge clk);
        sck_in = 0;
        if (poke && k == 3) begin wr_en = 1; wr_data = ~tx; start = 1; end
        repeat (4) @(negedge clk);
        wr_en = 0; start = 0;
        sck_in = 1;
      end
    end else if (poke) begin
      repeat (5) @(negedge clk);
      wr_en = 1; wr_data = ~tx; start = 1;
      @(negedge clk);
      wr_en = 0; start = 0;
    end
    wait_done();
    check("R8 done after eighth bit", done, 1);
    check("R7 received byte", rd_data, pat);
    if (!ext) begin
      check(lsb ? "R6 lsb-first send order" : "R5 msb-first send order", tx_seen, tx);
      check("R4 sck idles high after transfer", sck_out, 1);
    end else begin
      check("R9 sck_oe low in external mode", sck_oe, 0);
    end
  endtask

  initial begin
    rst_n = 0; cfg_enable = 1; cfg_lsb_first = 0; cfg_ext_clk = 0;
    wr_en = 0; wr_data = 0; start = 0; sck_in = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset done", done, 0);
    check("R1 reset sdo", sdo, 1);
    check("R1 reset rd_data", rd_data, 0);
    check("R1 reset sck_out", sck_out, 1);

    xfer(8'hA5, 8'h3C, 0, 0, 0);
    xfer(8'h96, 8'hC1, 1, 0, 1);   // R2 write while busy, R3 start while busy
    xfer(8'h5B, 8'hE2, 0, 1, 1);   // R9 external, msb first
    xfer(8'h71, 8'h0F, 1, 1, 0);   // R9 external, lsb first
    xfer(8'h00, 8'hFF, 0, 0, 0);

    // R10: serial function disabled
    @(negedge clk);
    cfg_enable = 0; cfg_ext_clk = 0;
    wr_en = 1; wr_data = 8'h5A;
    @(negedge clk);
    wr_en = 0; start = 1; pat_r = 8'h81;
    @(negedge clk);
    start = 0;
    repeat (30) @(negedge clk);
    check("R10 start ignored rd_data", rd_data, 8'h5A);
    check("R10 start ignored done", done, 1);
    check("R10 clock-out follows prescaler", sck_out, presc_clkout);
    check("R10 clock-out driven", sck_oe, 1);
    @(negedge clk);
    cfg_enable = 1;

    xfer(8'hC3, 8'h5A, 1, 0, 0);
    summary_and_end();
  end
endmodule